// File: doc/BRIEF.md
# Bus-Mapped Converter Interface Controller

This block is the device-side control logic that makes an 8-bit two-step converter look like one readable location on a processor bus. It samples the active-low chip select, read and write strobes together with a mode-select level and a power-down request. It then issues start and fine-step commands to a separate conversion sequencer and collects the coarse and fine nibbles of each result. The result comes back out on a data bus with an output enable, an active-low end-of-conversion flag and an open-drain wait indication. All timing is counted in system clocks.

With the mode level low, a read strobe both starts a conversion and waits for it. The wait line is pulled low until the result is ready. With the mode level high, a write strobe starts the conversion. The coarse nibble is captured when the write strobe ends, and the fine nibble is captured either after an internal delay or at once if the host reads early. If the write and read strobes are tied together, each access starts a new conversion while the previous result is shown on the bus. While the power-down request is active, start attempts are refused. After it is released, a wake-up and acquisition window must pass before a new start is accepted.

The sequencer interface is plain: the nibble inputs are levels that the sequencer holds, and the block samples them at fixed points. No back-pressure applies in either direction, because the host protocol sets the pace.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, int_n is 1, data_oe is 0, rdy_pull is 0, seq_start and seq_fine are 0, and data_o is 0x00.
- R2: data_oe is 1 exactly while the synchronised cs_n and rd_n are both low, and 0 otherwise.
- R3: With mode_i low, a falling rd_n while cs_n is low gives one seq_start pulse. RD_CONV_CYC cycles after that pulse, data_o becomes {coarse_i, fine_i} (coarse in bits 7:4) and int_n falls.
- R4: With mode_i low, rdy_pull goes to 1 after cs_n falls and returns to 0 when the conversion ends or cs_n rises. With mode_i high, rdy_pull stays 0.
- R5: int_n returns to 1 on a rising rd_n or cs_n, and also when a new conversion starts.
- R6: With mode_i high, a falling wr_n while cs_n is low gives a seq_start pulse. The rising wr_n latches coarse_i into bits 7:4 and gives a seq_fine pulse. FINE_CYC cycles after seq_fine, fine_i is latched into bits 3:0 and int_n falls. Changes to coarse_i after the rising wr_n do not reach data_o.
- R7: A falling rd_n with cs_n low while the fine delay is still running latches fine_i at once and drops int_n before FINE_CYC expires. Later changes of fine_i do not alter data_o.
- R8: With wr_n and rd_n falling together and cs_n low (mode_i high), a conversion starts while data_o, enabled, still shows the previous result. The new result arrives FINE_CYC cycles after the strobes rise.
- R9: While pd_i is high, no seq_start is issued for any strobe activity, and int_n stays unchanged.
- R10: After pd_i falls, a start strobe is ignored for WAKE_CYC+ACQ_CYC cycles. A strobe that comes later is accepted.
- R11: seq_start is a single-cycle pulse. A read strobe during a read-mode conversion does not start another conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| mode_i | input | 1 | 0: read-initiated mode, 1: write-read mode |
| pd_i | input | 1 | Power-down request, active high |
| coarse_i | input | NIB_W | Upper nibble held by the sequencer |
| fine_i | input | NIB_W | Lower nibble held by the sequencer |
| data_o | output | 2*NIB_W | Result register toward the bus driver |
| data_oe | output | 1 | Bus output enable |
| int_n | output | 1 | End-of-conversion flag, active low |
| rdy_pull | output | 1 | 1 = pull the open-drain wait line low |
| seq_start | output | 1 | Start pulse to the sequencer |
| seq_fine | output | 1 | Fine-step pulse to the sequencer |

## Verification
The hardest case to reach is the early-read override. The read strobe has to land inside the short window between the fine-step pulse and the end of the internal delay, and that window is already shortened by synchroniser latency. The stimulus waits for the seq_fine pulse itself and then drops rd_n a few cycles later. It next changes fine_i and holds the bus enabled past the point where the delay would have expired, which shows that the nibble was not captured a second time. The wake window after power-down is handled the same way: a strobe is placed inside the window and another after it.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RCONV = 2'd1,
    ST_WLOW  = 2'd2,
    ST_WFINE = 2'd3
  } ctl_state_e;

  localparam int unsigned LN_CS   = 0;
  localparam int unsigned LN_RD   = 1;
  localparam int unsigned LN_WR   = 2;
  localparam int unsigned LN_MODE = 3;
  localparam int unsigned LN_PD   = 4;
  localparam int unsigned LN_NUM  = 5;
endpackage

// File: rtl/adc_bus_sync.sv
module adc_bus_sync #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[b]}};
        last  <= RST_VAL[b];
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[b]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl_o[b]  = chain[STAGES-1];
    assign rise_o[b] = chain[STAGES-1] & ~last;
    assign fall_o[b] = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/adc_bus_timer.sv
module adc_bus_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/adc_bus_wake.sv
module adc_bus_wake #(
  parameter int unsigned WAKE_CYC = 10,
  parameter int unsigned ACQ_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  output logic ready_o
);
  localparam int unsigned TOTAL = WAKE_CYC + ACQ_CYC;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (pd_i)           hold_q <= CW'(TOTAL);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end
  assign ready_o = !pd_i && (hold_q == '0);
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RD_CONV_CYC = 35,
  parameter int unsigned FINE_CYC    = 19,
  parameter int unsigned WAKE_CYC    = 10,
  parameter int unsigned ACQ_CYC     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               mode_i,
  input  logic               pd_i,
  input  logic [NIB_W-1:0]   coarse_i,
  input  logic [NIB_W-1:0]   fine_i,
  output logic [2*NIB_W-1:0] data_o,
  output logic               data_oe,
  output logic               int_n,
  output logic               rdy_pull,
  output logic               seq_start,
  output logic               seq_fine
);
  localparam int unsigned DW    = 2 * NIB_W;
  localparam int unsigned TMAX  = (RD_CONV_CYC > FINE_CYC) ? RD_CONV_CYC : FINE_CYC;
  localparam int unsigned TCW   = $clog2(TMAX + 1);
  localparam logic [LN_NUM-1:0] SYNC_RST = 5'b00111;

  logic [LN_NUM-1:0] raw, lvl, rise, fall;
  assign raw = {pd_i, mode_i, wr_n, rd_n, cs_n};

  adc_bus_sync #(.WIDTH(LN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic sel, rd_act, mode_s, pd_s;
  logic rd_fall, rd_rise, wr_fall, wr_rise, cs_fall, cs_rise;
  assign sel     = !lvl[LN_CS];
  assign rd_act  = !lvl[LN_RD];
  assign mode_s  = lvl[LN_MODE];
  assign pd_s    = lvl[LN_PD];
  assign rd_fall = fall[LN_RD];
  assign rd_rise = rise[LN_RD];
  assign wr_fall = fall[LN_WR];
  assign wr_rise = rise[LN_WR];
  assign cs_fall = fall[LN_CS];
  assign cs_rise = rise[LN_CS];

  logic awake;
  adc_bus_wake #(.WAKE_CYC(WAKE_CYC), .ACQ_CYC(ACQ_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .pd_i(pd_s), .ready_o(awake)
  );

  ctl_state_e      state_q;
  logic [DW-1:0]   result_q;
  logic            int_q, rdy_q, start_q, fine_q;
  logic            go_rd, go_wr, coarse_take, fine_take;
  logic            tmr_load, tmr_done;
  logic [TCW-1:0]  tmr_val;

  assign go_rd = (state_q == ST_IDLE) && !mode_s && sel && rd_fall && awake;
  assign go_wr = (state_q == ST_IDLE) &&  mode_s && sel && wr_fall && awake;
  assign coarse_take = (state_q == ST_WLOW) && wr_rise;
  assign fine_take   = (state_q == ST_WFINE) && ((sel && rd_fall) || tmr_done);

  assign tmr_load = go_rd || coarse_take;
  assign tmr_val  = go_rd ? TCW'(RD_CONV_CYC) : TCW'(FINE_CYC);

  adc_bus_timer #(.CW(TCW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      int_q    <= 1'b1;
      rdy_q    <= 1'b0;
      start_q  <= 1'b0;
      fine_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      fine_q  <= 1'b0;
      if (rd_rise || cs_rise) int_q <= 1'b1;
      if (mode_s || cs_rise)  rdy_q <= 1'b0;
      else if (cs_fall)       rdy_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (go_rd) begin
            state_q <= ST_RCONV;
            start_q <= 1'b1;
            int_q   <= 1'b1;
          end else if (go_wr) begin
            state_q <= ST_WLOW;
            start_q <= 1'b1;
            int_q   <= 1'b1;
          end
        end
        ST_RCONV: begin
          if (tmr_done) begin
            result_q <= {coarse_i, fine_i};
            int_q    <= 1'b0;
            rdy_q    <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        ST_WLOW: begin
          if (coarse_take) begin
            result_q[DW-1:NIB_W] <= coarse_i;
            fine_q               <= 1'b1;
            state_q              <= ST_WFINE;
          end
        end
        ST_WFINE: begin
          if (fine_take) begin
            result_q[NIB_W-1:0] <= fine_i;
            int_q               <= 1'b0;
            state_q             <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o    = result_q;
  assign data_oe   = sel && rd_act;
  assign int_n     = int_q;
  assign rdy_pull  = rdy_q;
  assign seq_start = start_q;
  assign seq_fine  = fine_q;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk
  import adc_bus_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input ctl_state_e state_q,
  input logic       sel,
  input logic       rd_fall,
  input logic       rd_rise,
  input logic       cs_rise,
  input logic       mode_s,
  input logic       pd_s,
  input logic       seq_start,
  input logic       int_n,
  input logic       rdy_pull
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R11

  AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pd_s |=> !seq_start); // R9

  AST_RDY_QUIET_WR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |=> !rdy_pull); // R4

  AST_INT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_rise || cs_rise) && state_q == ST_IDLE) |=> int_n); // R5

  AST_EARLY_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WFINE && sel && rd_fall) |=> (!int_n && state_q == ST_IDLE)); // R7
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .sel(sel), .rd_fall(rd_fall),
  .rd_rise(rd_rise), .cs_rise(cs_rise), .mode_s(mode_s), .pd_s(pd_s),
  .seq_start(seq_start), .int_n(int_n), .rdy_pull(rdy_pull)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;
  localparam int RDC = 35;
  localparam int FNC = 19;
  localparam int WKC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode_i = 1'b0, pd_i = 1'b0;
  logic [3:0] coarse_i = 4'h0, fine_i = 4'h0;
  logic [7:0] data_o;
  logic data_oe, int_n, rdy_pull, seq_start, seq_fine;

  always #10 clk = ~clk;

  adc_bus_ctrl u_adc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode_i(mode_i), .pd_i(pd_i), .coarse_i(coarse_i), .fine_i(fine_i),
    .data_o(data_o), .data_oe(data_oe), .int_n(int_n), .rdy_pull(rdy_pull),
    .seq_start(seq_start), .seq_fine(seq_fine)
  );

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  bit done = 1'b0;
  string cur_tag = "R3";
  logic [7:0] exp_q[$];
  logic int_prev = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && seq_start) n_start++;

  // monitor: each end of conversion pops one expected result
  always @(negedge clk) begin
    if (rst_n && int_prev && !int_n) begin
      if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected result"}, data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(data_o == e, {cur_tag, " result"}, data_o, e);
      end
    end
    int_prev <= int_n;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_start(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20 && !ok; i++) begin
      @(negedge clk);
      if (seq_start) ok = 1'b1;
    end
  endtask

  task automatic wait_fine(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20 && !ok; i++) begin
      @(negedge clk);
      if (seq_fine) ok = 1'b1;
    end
  endtask

  task automatic count_int(output int n, output bit rdy_mid);
    n = 0;
    rdy_mid = 1'b0;
    while (int_n && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 3) rdy_mid = rdy_pull;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok, rm;
    int n, s0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(int_n == 1'b1 && data_oe == 1'b0 && rdy_pull == 1'b0, "R1 flags", {int_n, data_oe, rdy_pull}, 3'b100);
    chk(!seq_start && !seq_fine && data_o == 8'h00, "R1 data", data_o, 0);

    // R3/R4/R2 read-initiated conversion
    cur_tag = "R3";
    coarse_i = 4'hA; fine_i = 4'h5;
    exp_q.push_back(8'hA5);
    cs_n = 1'b0; rd_n = 1'b0;
    wait_start(ok);
    chk(ok, "R3 start pulse", ok, 1);
    count_int(n, rm);
    chk(n == RDC, "R3 conversion cycles", n, RDC);
    chk(rm == 1'b1, "R4 rdy low during conversion", rm, 1);
    chk(rdy_pull == 1'b0, "R4 rdy released at end", rdy_pull, 0);
    chk(data_oe == 1'b1, "R2 oe with cs and rd low", data_oe, 1);
    rd_n = 1'b1;
    cyc(4);
    chk(int_n == 1'b1, "R5 int high after rd rise", int_n, 1);
    chk(data_oe == 1'b0, "R2 oe off after rd rise", data_oe, 0);
    cs_n = 1'b1;
    cyc(4);

    // R11 second read strobe inside a conversion; R5 cs rise clears int
    cur_tag = "R11";
    coarse_i = 4'hC; fine_i = 4'h3;
    exp_q.push_back(8'hC3);
    s0 = n_start;
    cs_n = 1'b0; rd_n = 1'b0;
    cyc(10);
    rd_n = 1'b1; cyc(3); rd_n = 1'b0;
    n = 0;
    while (int_n && n < 100) begin @(negedge clk); n++; end
    chk(n_start - s0 == 1, "R11 single start", n_start - s0, 1);
    cs_n = 1'b1;
    cyc(4);
    chk(int_n == 1'b1, "R5 int high after cs rise", int_n, 1);
    rd_n = 1'b1;
    cyc(4);

    // R6 write-read with internal delay
    cur_tag = "R6";
    mode_i = 1'b1;
    cyc(4);
    chk(rdy_pull == 1'b0, "R4 rdy idle in write mode", rdy_pull, 0);
    coarse_i = 4'h7; fine_i = 4'h1;
    exp_q.push_back(8'h79);
    cs_n = 1'b0; wr_n = 1'b0;
    wait_start(ok);
    chk(ok, "R6 start on wr fall", ok, 1);
    cyc(3);
    wr_n = 1'b1;
    wait_fine(ok);
    chk(ok, "R6 fine pulse", ok, 1);
    coarse_i = 4'h0; fine_i = 4'h9;
    count_int(n, rm);
    chk(n == FNC, "R6 fine delay cycles", n, FNC);
    chk(rdy_pull == 1'b0, "R4 rdy stays off", rdy_pull, 0);
    rd_n = 1'b0;
    cyc(4);
    chk(data_oe && data_o == 8'h79, "R6 read back", data_o, 8'h79);
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(4);

    // R7 early read override
    cur_tag = "R7";
    coarse_i = 4'h4; fine_i = 4'hE;
    exp_q.push_back(8'h4E);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(5);
    wr_n = 1'b1;
    wait_fine(ok);
    cyc(3);
    rd_n = 1'b0;
    n = 3;
    while (int_n && n < 100) begin @(negedge clk); n++; end
    chk(n < FNC, "R7 int before delay", n, FNC);
    fine_i = 4'h2;
    cyc(FNC + 4);
    chk(data_oe && data_o == 8'h4E, "R7 no second capture", data_o, 8'h4E);
    rd_n = 1'b1;
    cyc(4);

    // R8 pipelined strobes
    cur_tag = "R8";
    coarse_i = 4'hB; fine_i = 4'h6;
    exp_q.push_back(8'hB6);
    s0 = n_start;
    wr_n = 1'b0; rd_n = 1'b0;
    cyc(5);
    chk(data_oe && data_o == 8'h4E, "R8 old data on bus", data_o, 8'h4E);
    chk(n_start - s0 == 1, "R8 new conversion started", n_start - s0, 1);
    wr_n = 1'b1; rd_n = 1'b1;
    wait_fine(ok);
    count_int(n, rm);
    chk(n == FNC, "R8 result delay", n, FNC);
    coarse_i = 4'h1; fine_i = 4'h2;
    exp_q.push_back(8'h12);
    wr_n = 1'b0; rd_n = 1'b0;
    cyc(5);
    chk(data_oe && data_o == 8'hB6, "R8 previous result shown", data_o, 8'hB6);
    chk(int_n == 1'b1, "R5 int high on new start", int_n, 1);
    wr_n = 1'b1; rd_n = 1'b1;
    cyc(FNC + 8);
    cs_n = 1'b1;
    cyc(4);

    // R9 power-down refuses starts
    cur_tag = "R9";
    pd_i = 1'b1;
    cyc(5);
    s0 = n_start;
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(6);
    wr_n = 1'b1; cs_n = 1'b1;
    cyc(6);
    chk(n_start == s0, "R9 no start in power-down", n_start - s0, 0);
    chk(int_n == 1'b1, "R9 int unchanged", int_n, 1);

    // R10 wake window
    cur_tag = "R10";
    pd_i = 1'b0;
    cyc(2);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(2);
    chk(n_start == s0, "R10 start refused while waking", n_start - s0, 0);
    cyc(WKC + 4);
    coarse_i = 4'hD; fine_i = 4'h8;
    exp_q.push_back(8'hD8);
    wr_n = 1'b0;
    wait_start(ok);
    chk(ok, "R10 start accepted after wake", ok, 1);
    wr_n = 1'b1;
    cyc(FNC + 8);
    cs_n = 1'b1;
    cyc(4);
    chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule